// File: doc/BRIEF.md
# Asynchronous SRAM Bus Controller

This block sits between a synchronous requester and an asynchronous byte-wide static RAM with two chip selects, one active low and one active high, an output-enable strobe and a write-enable strobe. Each accepted request becomes a single read or write on the memory pins. Every pin the block drives comes straight from a register, so the strobes never glitch. The length of each phase is a whole number of clocks. It is worked out at elaboration from the speed-grade parameter (45, 55 or 70 ns) and the clock period: the required nanoseconds are divided by the period and rounded up, with at least one clock per phase.

The request side is a valid/ready handshake. A request is taken on a rising edge where `req_valid` and `req_ready` are both high. While `req_ready` is low the requester must hold its request, and the block ignores the request fields. `req_ready` is high only while the controller is idle and no retention request is pending. Read data comes back with a one-cycle `rsp_valid` pulse. The response has no back-pressure, so the requester must accept it in that cycle.

A retention request lets the memory go to a low-supply state. The block first finishes any access already in progress. It then parks both chip selects at their inactive levels and raises `ret_ack`. When the request is released, the block keeps `req_ready` low for a recovery count before it takes new work. That count is the larger of `cfg_recov` and one read cycle.

Top module: `asram_ctrl`

## Requirements
- R1: While reset is held and right after it is released: `mem_cs_n`=1, `mem_cs`=0, `mem_oe_n`=1, `mem_we_n`=1, `mem_dq_oe`=0, `rsp_valid`=0 and `req_ready`=1.
- R2: A read holds both chip selects active and `mem_oe_n` low for RD = ceil(max(grade, oe_time)/clk) clocks, where oe_time is 25, 25 or 35 ns. The data bus is sampled on the last of those clocks. `rsp_valid` rises RD clocks after the accepting edge and carries that sample.
- R3: A write spends one clock with the selects active and both strobes high. It then holds `mem_we_n` low for WP = ceil(max(wp_time, setup_time)/clk) clocks, with wp_time 35, 40 or 50 ns and setup_time 25, 25 or 30 ns. A tail clocks with WE high follow, where tail = max(1, ceil(grade/clk) − WP − 1). Write data stays stable while WE is low, and `req_ready` returns 1+WP+tail clocks after acceptance.
- R4: `mem_dq_oe` is high only while `mem_we_n` is low. `mem_oe_n` is never low while `mem_we_n` is low or the bus is driven.
- R5: Outside an access both selects are inactive (`mem_cs_n`=1, `mem_cs`=0). During an access both are active.
- R6: A request is taken only on an edge where both `req_valid` and `req_ready` are high. A request held through a busy period is taken exactly once, after the access in progress completes.
- R7: Each read gives exactly one `rsp_valid` pulse, one clock wide. A write gives none.
- R8: When `ret_req` is raised, `req_ready` drops at once. Any access in progress completes, and the following clock shows `ret_ack`=1 with both selects inactive for as long as `ret_req` stays high.
- R9: After `ret_req` falls, `req_ready` stays low for max(`cfg_recov`, ceil(grade/clk)) clocks and then returns high.
- R10: `mem_addr` does not change while the chip selects stay active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | Read data valid, one-clock pulse |
| rsp_rdata | output | DATA_W | Read data |
| ret_req | input | 1 | Retention (standby) request |
| ret_ack | output | 1 | Memory is parked for retention |
| cfg_recov | input | RECOV_W | Recovery clocks after retention |
| mem_addr | output | ADDR_W | Memory address bus |
| mem_cs_n | output | 1 | Active-low chip select |
| mem_cs | output | 1 | Active-high chip select |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_we_n | output | 1 | Active-low write enable |
| mem_dq_out | output | DATA_W | Data driven toward memory |
| mem_dq_oe | output | 1 | Drive enable for the data bus |
| mem_dq_in | input | DATA_W | Data bus as seen from memory |

## Verification
Some properties are checked on every cycle:
- the bus is never driven against the memory output, and drive stays tied to the write strobe;
- the address and write data hold steady while selected or strobed;
- selects stay parked while `ret_ack` is high;
- phase counters do not leave a pulse or recovery early;
- a response follows only a read.

Other properties only the bench scenarios can show: whether the memory model saw a full access time before its data was sampled, and whether each write met its pulse width, data setup and cycle time in nanoseconds. The same holds for the data that lands at every address, the exact response and ready latencies, and the way a request, or a retention request, waits behind an access in progress.

// File: rtl/asram_pkg.sv
package asram_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_RD,
    S_WSU,
    S_WPL,
    S_WTL,
    S_RET,
    S_RECOV
  } phase_t;

  function automatic int ceil_div(input int n, input int d);
    return (n + d - 1) / d;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // minimum write-enable low time per speed grade
  function automatic int grade_wp_ns(input int g);
    if (g <= 45) return 35;
    else if (g <= 55) return 40;
    else return 50;
  endfunction

  // minimum data valid before end of write per speed grade
  function automatic int grade_dsu_ns(input int g);
    return (g <= 55) ? 25 : 30;
  endfunction

  // output-enable to valid data per speed grade
  function automatic int grade_oe_ns(input int g);
    return (g <= 55) ? 25 : 35;
  endfunction

endpackage

// File: rtl/asram_phase_cnt.sv
module asram_phase_cnt #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)             cnt_q <= '0;
    else if (load)          cnt_q <= load_val;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign zero = (cnt_q == '0);

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1)); // R3
endmodule

// File: rtl/asram_fsm.sv
module asram_fsm
  import asram_pkg::*;
#(
  parameter int CLK_NS   = 20,
  parameter int GRADE_NS = 45,
  parameter int RECOV_W  = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic               req_write,
  input  logic               ret_req,
  input  logic [RECOV_W-1:0] cfg_recov,
  output phase_t             state_d,
  output logic               req_ready,
  output logic               ret_ack,
  output logic               capture
);
  localparam int RC_CYC   = imax(1, ceil_div(GRADE_NS, CLK_NS));
  localparam int RD_CYC   = imax(RC_CYC, imax(1, ceil_div(grade_oe_ns(GRADE_NS), CLK_NS)));
  localparam int WP_CYC   = imax(1, imax(ceil_div(grade_wp_ns(GRADE_NS), CLK_NS),
                                         ceil_div(grade_dsu_ns(GRADE_NS), CLK_NS)));
  localparam int TAIL_CYC = imax(1, RC_CYC - WP_CYC - 1);
  localparam int MAXLEN   = imax(imax(RD_CYC, WP_CYC), imax(TAIL_CYC, (1 << RECOV_W) + RC_CYC));
  localparam int CNT_W    = $clog2(MAXLEN + 1);

  localparam logic [CNT_W-1:0] RD_LD   = CNT_W'(RD_CYC - 1);
  localparam logic [CNT_W-1:0] WP_LD   = CNT_W'(WP_CYC - 1);
  localparam logic [CNT_W-1:0] TAIL_LD = CNT_W'(TAIL_CYC - 1);
  localparam logic [CNT_W-1:0] RC_LEN  = CNT_W'(RC_CYC);

  phase_t           state_q;
  logic             cnt_load;
  logic [CNT_W-1:0] cnt_val;
  logic             cnt_zero;
  logic [CNT_W-1:0] rec_len;

  assign rec_len = (CNT_W'(cfg_recov) > RC_LEN) ? CNT_W'(cfg_recov) : RC_LEN;

  always_comb begin
    state_d  = state_q;
    cnt_load = 1'b0;
    cnt_val  = '0;
    unique case (state_q)
      S_IDLE: begin
        if (ret_req) begin
          state_d = S_RET;
        end else if (req_valid) begin
          if (req_write) begin
            state_d = S_WSU;
          end else begin
            state_d  = S_RD;
            cnt_load = 1'b1;
            cnt_val  = RD_LD;
          end
        end
      end
      S_RD:    if (cnt_zero) state_d = S_IDLE;
      S_WSU: begin
        state_d  = S_WPL;
        cnt_load = 1'b1;
        cnt_val  = WP_LD;
      end
      S_WPL: begin
        if (cnt_zero) begin
          state_d  = S_WTL;
          cnt_load = 1'b1;
          cnt_val  = TAIL_LD;
        end
      end
      S_WTL:   if (cnt_zero) state_d = S_IDLE;
      S_RET: begin
        if (!ret_req) begin
          state_d  = S_RECOV;
          cnt_load = 1'b1;
          cnt_val  = rec_len - 1'b1;
        end
      end
      S_RECOV: if (cnt_zero) state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= S_IDLE;
    else        state_q <= state_d;
  end

  asram_phase_cnt #(.W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (cnt_load),
    .load_val (cnt_val),
    .zero     (cnt_zero)
  );

  assign req_ready = (state_q == S_IDLE) && !ret_req;
  assign ret_ack   = (state_q == S_RET);
  assign capture   = (state_q == S_RD) && cnt_zero;

  AST_WP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_WPL && !cnt_zero) |=> (state_q == S_WPL)); // R3
  AST_RD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_RD && !cnt_zero) |=> (state_q == S_RD)); // R2
  AST_RECOV_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_RECOV && !cnt_zero) |=> (state_q == S_RECOV && !req_ready)); // R9
  AST_RET_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_req && state_q == S_RD) |=> (state_q != S_RET)); // R8
endmodule

// File: rtl/asram_pins.sv
module asram_pins
  import asram_pkg::*;
#(
  parameter int ADDR_W = 18,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  phase_t            state_d,
  input  logic              capture,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [DATA_W-1:0] mem_dq_in,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_cs_n,
  output logic              mem_cs,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata
);
  logic sel_d, oe_d, we_d, drv_d;

  always_comb begin
    sel_d = 1'b0;
    oe_d  = 1'b0;
    we_d  = 1'b0;
    drv_d = 1'b0;
    unique case (state_d)
      S_RD:  begin sel_d = 1'b1; oe_d = 1'b1; end
      S_WSU: sel_d = 1'b1;
      S_WPL: begin sel_d = 1'b1; we_d = 1'b1; drv_d = 1'b1; end
      S_WTL: sel_d = 1'b1;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mem_cs_n  <= 1'b1;
      mem_cs    <= 1'b0;
      mem_oe_n  <= 1'b1;
      mem_we_n  <= 1'b1;
      mem_dq_oe <= 1'b0;
    end else begin
      mem_cs_n  <= !sel_d;
      mem_cs    <= sel_d;
      mem_oe_n  <= !oe_d;
      mem_we_n  <= !we_d;
      mem_dq_oe <= drv_d;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mem_addr   <= '0;
      mem_dq_out <= '0;
    end else if (accept) begin
      mem_addr   <= req_addr;
      mem_dq_out <= req_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= capture;
      if (capture) rsp_rdata <= mem_dq_in;
    end
  end

  AST_DRIVE_WE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> !mem_we_n); // R4
  AST_NO_FIGHT: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> (mem_we_n && !mem_dq_oe)); // R4
  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_cs_n && $past(!mem_cs_n)) |-> $stable(mem_addr)); // R10
  AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_we_n && $past(!mem_we_n)) |-> $stable(mem_dq_out)); // R3
  AST_SEL_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_cs_n != mem_cs)); // R5
  AST_STROBE_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_oe_n || !mem_we_n) |-> !mem_cs_n); // R5
endmodule

// File: rtl/asram_ctrl.sv
module asram_ctrl
  import asram_pkg::*;
#(
  parameter int ADDR_W   = 18,
  parameter int DATA_W   = 8,
  parameter int CLK_NS   = 20,
  parameter int GRADE_NS = 45,
  parameter int RECOV_W  = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic               req_write,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic [DATA_W-1:0]  req_wdata,
  output logic               rsp_valid,
  output logic [DATA_W-1:0]  rsp_rdata,
  input  logic               ret_req,
  output logic               ret_ack,
  input  logic [RECOV_W-1:0] cfg_recov,
  output logic [ADDR_W-1:0]  mem_addr,
  output logic               mem_cs_n,
  output logic               mem_cs,
  output logic               mem_oe_n,
  output logic               mem_we_n,
  output logic [DATA_W-1:0]  mem_dq_out,
  output logic               mem_dq_oe,
  input  logic [DATA_W-1:0]  mem_dq_in
);
  phase_t state_d;
  logic   capture;
  logic   accept;

  assign accept = req_valid && req_ready;

  asram_fsm #(
    .CLK_NS   (CLK_NS),
    .GRADE_NS (GRADE_NS),
    .RECOV_W  (RECOV_W)
  ) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .ret_req   (ret_req),
    .cfg_recov (cfg_recov),
    .state_d   (state_d),
    .req_ready (req_ready),
    .ret_ack   (ret_ack),
    .capture   (capture)
  );

  asram_pins #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_pins (
    .clk        (clk),
    .rst_n      (rst_n),
    .accept     (accept),
    .state_d    (state_d),
    .capture    (capture),
    .req_addr   (req_addr),
    .req_wdata  (req_wdata),
    .mem_dq_in  (mem_dq_in),
    .mem_addr   (mem_addr),
    .mem_cs_n   (mem_cs_n),
    .mem_cs     (mem_cs),
    .mem_oe_n   (mem_oe_n),
    .mem_we_n   (mem_we_n),
    .mem_dq_out (mem_dq_out),
    .mem_dq_oe  (mem_dq_oe),
    .rsp_valid  (rsp_valid),
    .rsp_rdata  (rsp_rdata)
  );

  AST_RET_DESEL: assert property (@(posedge clk) disable iff (!rst_n)
    ret_ack |-> (mem_cs_n && !mem_cs)); // R8
  AST_ACCEPT_SELECTS: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !mem_cs_n); // R6
  AST_RSP_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> ($past(!mem_oe_n) && !$past(rsp_valid))); // R7
endmodule

// File: tb/asram_ctrl_tb.sv
module asram_ctrl_tb;
  localparam int CLK   = 20;
  localparam int GRADE = 45;
  localparam int AW    = 10;
  localparam int DW    = 8;
  localparam int RW    = 8;

  function automatic int cdiv(input int n, input int d); return (n + d - 1) / d; endfunction
  function automatic int mx(input int a, input int b); return (a > b) ? a : b; endfunction

  localparam int WP_NS  = (GRADE <= 45) ? 35 : ((GRADE <= 55) ? 40 : 50);
  localparam int DSU_NS = (GRADE <= 55) ? 25 : 30;
  localparam int OE_NS  = (GRADE <= 55) ? 25 : 35;
  localparam int RC_EXP = mx(1, cdiv(GRADE, CLK));
  localparam int RD_EXP = mx(RC_EXP, cdiv(OE_NS, CLK));
  localparam int WP_EXP = mx(1, mx(cdiv(WP_NS, CLK), cdiv(DSU_NS, CLK)));
  localparam int WR_EXP = 1 + WP_EXP + mx(1, RC_EXP - WP_EXP - 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, ret_req = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic [RW-1:0] cfg_recov = '0;
  logic req_ready, rsp_valid, ret_ack;
  logic [DW-1:0] rsp_rdata;
  logic [AW-1:0] mem_addr;
  logic mem_cs_n, mem_cs, mem_oe_n, mem_we_n, mem_dq_oe;
  logic [DW-1:0] mem_dq_out;
  logic [DW-1:0] mem_dq_in = '0;

  always #(CLK/2) clk = ~clk;

  asram_ctrl #(.ADDR_W(AW), .DATA_W(DW), .CLK_NS(CLK), .GRADE_NS(GRADE), .RECOV_W(RW)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .ret_req(ret_req), .ret_ack(ret_ack),
    .cfg_recov(cfg_recov), .mem_addr(mem_addr), .mem_cs_n(mem_cs_n), .mem_cs(mem_cs),
    .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_dq_out(mem_dq_out),
    .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in));

  int checks = 0, fails = 0;
  int reads = 0, rsp_cnt = 0, accepts = 0;
  bit done = 1'b0;
  bit in_write = 1'b0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // ---------------- memory model (pins sampled mid-cycle) ----------------
  logic [DW-1:0] mem [1 << AW];
  int cyc = 0, last_start = 0, we_age = 0, d_age = 0, a_age = 0, oe_age = 0;
  bit have_start = 0, wr_prev = 0, have_a = 0;
  logic [AW-1:0] waddr, last_a;
  logic [DW-1:0] wdat;

  initial for (int i = 0; i < (1 << AW); i++) mem[i] = '0;

  always @(negedge clk) begin
    if (rst_n) begin
      bit sel, wr_now, rd_now;
      sel    = !mem_cs_n && mem_cs;
      wr_now = sel && !mem_we_n;
      rd_now = sel && !mem_oe_n && mem_we_n;
      if (mem_dq_oe && (mem_we_n || !mem_oe_n))
        chk(0, "R4 bus driven outside write", 1, 0);
      if (wr_now) begin
        if (!wr_prev) begin
          if (have_start)
            chk((cyc - last_start) * CLK >= GRADE, "R3 write cycle ns", (cyc - last_start) * CLK, GRADE);
          have_start = 1; last_start = cyc; we_age = 1;
          waddr = mem_addr; wdat = mem_dq_out; d_age = mem_dq_oe ? 1 : 0;
        end else begin
          we_age++;
          if (mem_addr != waddr) chk(0, "R10 address moved in write", int'(mem_addr), int'(waddr));
          if (mem_dq_oe && mem_dq_out == wdat) d_age++;
          else begin wdat = mem_dq_out; d_age = mem_dq_oe ? 1 : 0; end
        end
      end else if (wr_prev) begin
        chk(we_age * CLK >= WP_NS, "R3 WE low ns", we_age * CLK, WP_NS);
        chk(d_age * CLK >= DSU_NS, "R3 data setup ns", d_age * CLK, DSU_NS);
        mem[waddr] = wdat;
      end
      wr_prev = wr_now;
      if (sel && have_a && mem_addr == last_a) a_age++;
      else a_age = sel ? 1 : 0;
      have_a = sel; last_a = mem_addr;
      oe_age = rd_now ? oe_age + 1 : 0;
      if (rd_now)
        mem_dq_in = (a_age * CLK >= GRADE && oe_age * CLK >= OE_NS) ? mem[mem_addr] : ~mem[mem_addr];
      else
        mem_dq_in = '0;
      cyc++;
    end
  end

  always @(negedge clk) if (rst_n && rsp_valid) begin
    rsp_cnt++;
    if (in_write) chk(0, "R7 response during write", 1, 0);
  end
  always @(posedge clk) if (rst_n && req_valid && req_ready) accepts++;

  // ---------------- stimulus helpers ----------------
  task automatic send(input bit wr, input int a, input int d);
    @(negedge clk);
    req_valid = 1; req_write = wr; req_addr = AW'(a); req_wdata = DW'(d);
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic do_write(input int a, input int d);
    int n;
    in_write = 1;
    send(1, a, d);
    n = 1;
    while (!req_ready) begin @(negedge clk); n++; end
    chk(n == WR_EXP + 1 || n == WR_EXP, "R3 write occupancy", n, WR_EXP);
    in_write = 0;
  endtask

  task automatic do_read(input int a, input int exp);
    int n;
    send(0, a, 0);
    reads++;
    n = 0;
    chk(!rsp_valid, "R2 no early response", int'(rsp_valid), 0);
    while (!rsp_valid && n < 50) begin @(negedge clk); n++; end
    chk(n == RD_EXP, "R2 read latency", n, RD_EXP);
    chk(rsp_rdata == DW'(exp), "R2 read data", int'(rsp_rdata), exp);
    @(negedge clk);
    chk(!rsp_valid, "R7 single pulse", int'(rsp_valid), 0);
  endtask

  function automatic int pat(input int a, input int s);
    return int'(DW'((a * 37 + s * 11) ^ (a >> 3)));
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int n, acc0, rsp0;
    repeat (3) @(negedge clk);
    chk(mem_cs_n && !mem_cs && mem_oe_n && mem_we_n && !mem_dq_oe, "R1 pins in reset", 0, 1);
    rst_n = 1;
    @(negedge clk);
    chk(mem_cs_n && !mem_cs && mem_oe_n && mem_we_n && !mem_dq_oe, "R1 pins after reset", 0, 1);
    chk(req_ready && !rsp_valid, "R1 ready/response", int'(req_ready), 1);
    chk(mem_cs_n && !mem_cs, "R5 idle selects inactive", int'(mem_cs), 0);

    // full sweep: write all, then read all
    for (int a = 0; a < (1 << AW); a++) do_write(a, pat(a, 0));
    for (int a = 0; a < (1 << AW); a++) do_read(a, pat(a, 0));
    // read-after-write on a slice with a second pattern
    for (int a = 0; a < 256; a++) begin
      do_write(a, pat(a, 1));
      do_read(a, pat(a, 1));
    end

    // R6: request held through a busy period
    acc0 = accepts;
    @(negedge clk);
    req_valid = 1; req_write = 1; req_addr = 10'd5; req_wdata = 8'hA5;
    while (!req_ready) @(negedge clk);
    @(posedge clk); #1;
    req_addr = 10'd6; req_wdata = 8'h5A;
    @(negedge clk);
    chk(!req_ready, "R6 ready low while busy", int'(req_ready), 0);
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    req_valid = 0;
    while (!req_ready) @(negedge clk);
    chk(accepts - acc0 == 2, "R6 accept count", accepts - acc0, 2);
    do_read(5, 8'hA5);
    do_read(6, 8'h5A);

    // R8: retention request during a write
    in_write = 1;
    send(1, 7, 8'h3C);
    ret_req = 1;
    n = 0;
    while (!ret_ack && n < 50) begin
      chk(!req_ready, "R8 ready low pending retention", int'(req_ready), 0);
      @(negedge clk); n++;
    end
    in_write = 0;
    chk(n == WR_EXP + 1, "R8 retention after access", n, WR_EXP + 1);
    for (int i = 0; i < 5; i++) begin
      chk(ret_ack && mem_cs_n && !mem_cs, "R8 parked", int'(mem_cs_n), 1);
      @(negedge clk);
    end
    // R9: programmed recovery
    cfg_recov = 8'd7;
    ret_req = 0;
    n = 0;
    @(negedge clk);
    while (!req_ready && n < 300) begin n++; @(negedge clk); end
    chk(n == mx(7, RC_EXP), "R9 recovery programmed", n, mx(7, RC_EXP));
    do_read(7, 8'h3C);

    // R8 from idle, then R9 with a count below the floor
    @(negedge clk);
    ret_req = 1; #1;
    chk(!req_ready, "R8 ready drops at once", int'(req_ready), 0);
    @(negedge clk);
    chk(ret_ack && mem_cs_n, "R8 idle entry", int'(ret_ack), 1);
    cfg_recov = 8'd0;
    @(negedge clk);
    ret_req = 0;
    n = 0;
    @(negedge clk);
    while (!req_ready && n < 300) begin n++; @(negedge clk); end
    chk(n == RC_EXP, "R9 recovery floor", n, RC_EXP);
    do_read(6, 8'h5A);

    repeat (4) @(negedge clk);
    chk(rsp_cnt == reads, "R7 responses per read", rsp_cnt, reads);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule